// File: doc/BRIEF.md
# SD Host Transfer State Tracker

This block follows the command and data activity of an SD host controller and keeps the status flags that software polls before it issues the next command. A write of the command register arrives as a single-cycle strobe, together with the transfer-mode fields of that command. The tracker decides whether the command may be issued. It then follows the command response, the data phase in either direction, the block counting and the optional automatic stop command. It also handles pauses at a block gap and the resume that follows.

The card side reports events as single-cycle strobes: the response end bit of the current command, a read block delivered to the system, the CRC status of a written block, and the response of the automatic stop command. Software reports two more: a level that asks the transfer to stop at the next block gap, and a strobe that asks a parked transfer to continue. The outputs are the command and data inhibit flags, the read and write active flags, the remaining block count, a request to send the stop command, and one-cycle pulses for command complete, transfer complete, block-gap event and command conflict.

Top module: `sd_xfer_tracker`

## Requirements
- R1: After reset every flag, every pulse, the stop request and the block count are 0.
- R2: A command write that is not refused sets cmdInhibit from the next cycle. cmdInhibit stays set until rspDone. cmdComplete is high for exactly the one cycle in which cmdInhibit first reads 0 again.
- R3: A command write while cmdInhibit is 1 is refused. cmdConflict pulses for one cycle, cmdInhibit stays 1 and cmdComplete does not pulse. The block count and the transfer flags are unchanged.
- R4: A command with cmdDataPresent=0 is accepted while datInhibit is 1, provided cmdInhibit is 0. A data command is refused, as in R3, while datInhibit is 1 or while a transfer is parked at a block gap.
- R5: The rspDone of a read data command (cmdRead=1) sets readActive. Each blkDone while readActive is set completes one block, and the last block clears readActive. blkDone and crcDone outside their own active phase are ignored. readActive and writeActive are never both 1.
- R6: The rspDone of a write data command (cmdRead=0) sets writeActive. Each crcDone while writeActive is set completes one block, and the last block clears writeActive.
- R7: Every accepted data command loads blkCount from cmdBlkCount. The count decrements once per completed block, but only when cmdMulti=1 and cmdCountEn=1, and it never goes below 0. The last block is the one completed when the count is 1 or less. With cmdMulti=0 the first block is the last. With cmdMulti=1 and cmdCountEn=0 no block is last.
- R8: If cmdMulti=1 and cmdAutoStop=1, completing the last block raises autoStopReq. autoStopReq holds until stopDone, and datInhibit stays 1 until then.
- R9: A block that completes while gapStop is 1 and is not the last one parks the transfer. The active flag clears and gapEvent pulses for one cycle. The block count keeps its value.
- R10: A gapContinue while the transfer is parked and gapStop is 0 sets the active flag of the same direction again, and counting resumes from the kept value. A gapContinue while gapStop is 1 is ignored.
- R11: datInhibit is 1 while a data command waits for its response, during a read or write phase, and while a stop request is pending. xferComplete is high for exactly the one cycle in which datInhibit first reads 0 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdWrite | input | 1 | Command register write strobe |
| cmdDataPresent | input | 1 | Command uses the data lines |
| cmdRead | input | 1 | 1 = card to host, 0 = host to card |
| cmdMulti | input | 1 | Multi-block transfer |
| cmdCountEn | input | 1 | Use the block count |
| cmdAutoStop | input | 1 | Send a stop command after the last block |
| cmdBlkCount | input | CNT_W | Block count loaded with a data command |
| rspDone | input | 1 | Response end bit of the current command |
| blkDone | input | 1 | Read block delivered to the system |
| crcDone | input | 1 | CRC status received for a written block |
| stopDone | input | 1 | Response of the automatic stop command |
| gapStop | input | 1 | Stop-at-block-gap request level |
| gapContinue | input | 1 | Continue request strobe |
| cmdInhibit | output | 1 | CMD line busy |
| datInhibit | output | 1 | DAT side busy |
| readActive | output | 1 | Read transfer active |
| writeActive | output | 1 | Write transfer active |
| blkCount | output | CNT_W | Remaining block count |
| autoStopReq | output | 1 | Request to send the stop command |
| cmdComplete | output | 1 | Command complete pulse |
| xferComplete | output | 1 | Transfer complete pulse |
| gapEvent | output | 1 | Block-gap event pulse |
| cmdConflict | output | 1 | Refused command pulse |

## Verification
The bench builds the tracker with CNT_W=4, so the full range of block counts, 1 to 15, can be swept exhaustively. The sweep covers both directions, with and without the automatic stop. For each run the bench works out the remaining count after every block and the cycle in which the transfer ends. The narrow counter also makes a zero load cheap to test: a zero load ends the transfer after one block and must not wrap. Separate sequences cover refused commands, commands that use only the CMD line during a read, parking at a block gap with continues both blocked and allowed, a single-block transfer, and an uncounted multi-block transfer.

// File: rtl/sdx_pkg.sv
package sdx_pkg;
  typedef struct packed {
    logic load;
    logic dec;
  } sdxStrobe_t;

  typedef struct packed {
    logic read;
    logic multi;
    logic countEn;
    logic autoStop;
  } sdxCfg_t;
endpackage

// File: rtl/sdx_dpath.sv
module sdx_dpath
  import sdx_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  sdxStrobe_t       strobe,
  input  sdxCfg_t          cfgIn,
  input  logic [CNT_W-1:0] countIn,
  output sdxCfg_t          cfg,
  output logic [CNT_W-1:0] blkCount,
  output logic             isLast
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] ZERO = '0;

  logic useCount;
  assign useCount = cfg.multi & cfg.countEn;
  assign isLast   = useCount ? (blkCount <= ONE) : ~cfg.multi;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfg      <= '0;
      blkCount <= '0;
    end else if (strobe.load) begin
      cfg      <= cfgIn;
      blkCount <= countIn;
    end else if (strobe.dec && blkCount != ZERO) begin
      blkCount <= blkCount - ONE;
    end
  end

  // R7: a new command is never loaded while a block is being counted
  p_load_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |-> !strobe.dec);
endmodule

// File: rtl/sdx_ctrl.sv
module sdx_ctrl
  import sdx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdWrite,
  input  logic       cmdDataPresent,
  input  logic       rspDone,
  input  logic       blkDone,
  input  logic       crcDone,
  input  logic       stopDone,
  input  logic       gapStop,
  input  logic       gapContinue,
  input  sdxCfg_t    cfg,
  input  logic       isLast,
  output sdxStrobe_t strobe,
  output logic       cmdInhibit,
  output logic       datInhibit,
  output logic       readActive,
  output logic       writeActive,
  output logic       autoStopReq,
  output logic       cmdComplete,
  output logic       xferComplete,
  output logic       gapEvent,
  output logic       cmdConflict
);
  logic pendingData, parked, stopPending;
  logic cmdInhibitQ, datInhibitQ;
  logic accept, startXfer, blockEv, resume, endXfer, parkNow;

  assign datInhibit = pendingData | readActive | writeActive | stopPending;
  assign accept     = cmdWrite & ~cmdInhibit
                    & ~(cmdDataPresent & (datInhibit | parked));
  assign startXfer  = rspDone & cmdInhibit & pendingData;
  assign blockEv    = (readActive & blkDone) | (writeActive & crcDone);
  assign endXfer    = blockEv & isLast;
  assign parkNow    = blockEv & ~isLast & gapStop;
  assign resume     = gapContinue & parked & ~gapStop;

  assign strobe.load = accept & cmdDataPresent;
  assign strobe.dec  = blockEv & cfg.multi & cfg.countEn;

  assign autoStopReq  = stopPending;
  assign cmdComplete  = cmdInhibitQ & ~cmdInhibit;
  assign xferComplete = datInhibitQ & ~datInhibit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdInhibit  <= 1'b0;
      pendingData <= 1'b0;
      readActive  <= 1'b0;
      writeActive <= 1'b0;
      parked      <= 1'b0;
      stopPending <= 1'b0;
      gapEvent    <= 1'b0;
      cmdConflict <= 1'b0;
      cmdInhibitQ <= 1'b0;
      datInhibitQ <= 1'b0;
    end else begin
      cmdInhibitQ <= cmdInhibit;
      datInhibitQ <= datInhibit;
      cmdConflict <= cmdWrite & ~accept;
      gapEvent    <= parkNow;

      if (accept)       cmdInhibit <= 1'b1;
      else if (rspDone) cmdInhibit <= 1'b0;

      if (accept && cmdDataPresent) pendingData <= 1'b1;
      else if (startXfer)           pendingData <= 1'b0;

      if ((startXfer || resume) && cfg.read) readActive <= 1'b1;
      else if (readActive && (endXfer || parkNow)) readActive <= 1'b0;

      if ((startXfer || resume) && !cfg.read) writeActive <= 1'b1;
      else if (writeActive && (endXfer || parkNow)) writeActive <= 1'b0;

      if (parkNow)     parked <= 1'b1;
      else if (resume) parked <= 1'b0;

      if (endXfer && cfg.multi && cfg.autoStop) stopPending <= 1'b1;
      else if (stopDone)                        stopPending <= 1'b0;
    end
  end

  // R2: an accepted command raises the CMD inhibit
  p_inhibit_on_accept_r2: assert property (@(posedge clk) disable iff (!rstN)
    cmdWrite && !cmdInhibit && !cmdDataPresent |=> cmdInhibit);
  // R3: a refused command leaves the inhibit set and completes nothing
  p_conflict_keeps_r3: assert property (@(posedge clk) disable iff (!rstN)
    cmdWrite && cmdInhibit |=> cmdInhibit && cmdConflict && !cmdComplete);
  // R5: the two directions never overlap
  p_rw_exclusive_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(readActive && writeActive));
  // R8: a stop request only follows a multi-block transfer with auto stop
  p_stop_only_multi_r8: assert property (@(posedge clk) disable iff (!rstN)
    autoStopReq |-> cfg.multi && cfg.autoStop);
  // R9: a block-gap event leaves the data side idle
  p_gap_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    gapEvent |-> !readActive && !writeActive && !datInhibit);
endmodule

// File: rtl/sd_xfer_tracker.sv
module sd_xfer_tracker
  import sdx_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdWrite,
  input  logic             cmdDataPresent,
  input  logic             cmdRead,
  input  logic             cmdMulti,
  input  logic             cmdCountEn,
  input  logic             cmdAutoStop,
  input  logic [CNT_W-1:0] cmdBlkCount,
  input  logic             rspDone,
  input  logic             blkDone,
  input  logic             crcDone,
  input  logic             stopDone,
  input  logic             gapStop,
  input  logic             gapContinue,
  output logic             cmdInhibit,
  output logic             datInhibit,
  output logic             readActive,
  output logic             writeActive,
  output logic [CNT_W-1:0] blkCount,
  output logic             autoStopReq,
  output logic             cmdComplete,
  output logic             xferComplete,
  output logic             gapEvent,
  output logic             cmdConflict
);
  sdxStrobe_t strobe;
  sdxCfg_t    cfgIn, cfg;
  logic       isLast;

  assign cfgIn = '{read: cmdRead, multi: cmdMulti, countEn: cmdCountEn,
                   autoStop: cmdAutoStop};

  sdx_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .cmdWrite(cmdWrite), .cmdDataPresent(cmdDataPresent),
    .rspDone(rspDone), .blkDone(blkDone), .crcDone(crcDone), .stopDone(stopDone),
    .gapStop(gapStop), .gapContinue(gapContinue), .cfg(cfg), .isLast(isLast),
    .strobe(strobe), .cmdInhibit(cmdInhibit), .datInhibit(datInhibit),
    .readActive(readActive), .writeActive(writeActive), .autoStopReq(autoStopReq),
    .cmdComplete(cmdComplete), .xferComplete(xferComplete), .gapEvent(gapEvent),
    .cmdConflict(cmdConflict)
  );

  sdx_dpath #(.CNT_W(CNT_W)) dpath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgIn(cfgIn), .countIn(cmdBlkCount),
    .cfg(cfg), .blkCount(blkCount), .isLast(isLast)
  );
endmodule

// File: tb/sd_xfer_tracker_tb_top.sv
module sd_xfer_tracker_tb_top;
  localparam int CW = 4;
  logic clk = 0, rstN = 0;
  logic cmdWrite = 0, cmdDataPresent = 0, cmdRead = 0, cmdMulti = 0;
  logic cmdCountEn = 0, cmdAutoStop = 0;
  logic [CW-1:0] cmdBlkCount = '0;
  logic rspDone = 0, blkDone = 0, crcDone = 0, stopDone = 0;
  logic gapStop = 0, gapContinue = 0;
  logic cmdInhibit, datInhibit, readActive, writeActive, autoStopReq;
  logic cmdComplete, xferComplete, gapEvent, cmdConflict;
  logic [CW-1:0] blkCount;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sd_xfer_tracker #(.CNT_W(CW)) dut_i (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic issue(input bit dp, input bit rd, input bit mu, input bit ce,
                       input bit au, input int n);
    cmdWrite = 1; cmdDataPresent = dp; cmdRead = rd; cmdMulti = mu;
    cmdCountEn = ce; cmdAutoStop = au; cmdBlkCount = CW'(n);
    @(negedge clk);
    cmdWrite = 0;
  endtask

  task automatic pulseRsp();
    rspDone = 1; @(negedge clk); rspDone = 0;
  endtask

  task automatic pulseBlk(input bit rd);
    if (rd) blkDone = 1; else crcDone = 1;
    @(negedge clk);
    blkDone = 0; crcDone = 0;
  endtask

  function automatic int act(input bit rd);
    return rd ? int'(readActive) : int'(writeActive);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 cmdInhibit", cmdInhibit, 0); chk("R1 datInhibit", datInhibit, 0);
    chk("R1 active", readActive | writeActive, 0); chk("R1 count", blkCount, 0);
    chk("R1 pulses", cmdComplete | xferComplete | gapEvent | cmdConflict | autoStopReq, 0);
    rstN = 1; @(negedge clk);

    // R5 events while idle are ignored
    pulseBlk(1); pulseBlk(0);
    chk("R5 idle events", readActive | writeActive | datInhibit, 0);

    // R2/R3 command-only path and conflict
    issue(0, 0, 0, 0, 0, 0);
    chk("R2 inhibit set", cmdInhibit, 1); chk("R2 no dat", datInhibit, 0);
    issue(1, 1, 1, 1, 0, 9);
    chk("R3 conflict pulse", cmdConflict, 1); chk("R3 inhibit held", cmdInhibit, 1);
    chk("R3 no complete", cmdComplete, 0); chk("R3 count kept", blkCount, 0);
    chk("R3 no data", datInhibit, 0);
    pulseRsp();
    chk("R2 inhibit clear", cmdInhibit, 0); chk("R2 complete pulse", cmdComplete, 1);
    @(negedge clk);
    chk("R2 pulse one cycle", cmdComplete, 0); chk("R3 conflict one cycle", cmdConflict, 0);

    // R5-R8, R11 exhaustive sweep of counts, directions, auto stop
    for (int rd = 0; rd < 2; rd++)
      for (int au = 0; au < 2; au++)
        for (int n = 1; n < 16; n++) begin
          issue(1, rd[0], 1, 1, au[0], n);
          chk("R11 pending data", datInhibit, 1); chk("R7 load", blkCount, n);
          pulseRsp();
          chk(rd ? "R5 read set" : "R6 write set", act(rd[0]), 1);
          chk("R5 exclusive", readActive & writeActive, 0);
          for (int b = 1; b <= n; b++) begin
            pulseBlk(rd[0]);
            chk("R7 count step", blkCount, n - b);
            if (b < n) chk(rd ? "R5 still active" : "R6 still active", act(rd[0]), 1);
          end
          chk(rd ? "R5 last clears" : "R6 last clears", act(rd[0]), 0);
          if (au) begin
            chk("R8 stop req", autoStopReq, 1); chk("R8 dat held", datInhibit, 1);
            chk("R8 no complete", xferComplete, 0);
            @(negedge clk);
            chk("R8 stop held", autoStopReq, 1);
            stopDone = 1; @(negedge clk); stopDone = 0;
            chk("R8 stop clear", autoStopReq, 0);
          end else begin
            chk("R8 no stop", autoStopReq, 0);
          end
          chk("R11 dat clear", datInhibit, 0); chk("R11 complete", xferComplete, 1);
          @(negedge clk);
          chk("R11 one cycle", xferComplete, 0);
        end

    // R7 zero load ends after one block without wrapping
    issue(1, 1, 1, 1, 0, 0); pulseRsp(); pulseBlk(1);
    chk("R7 zero load ends", readActive, 0); chk("R7 no wrap", blkCount, 0);

    // R7 single block: first block last, count not decremented
    issue(1, 0, 0, 1, 1, 6); pulseRsp(); pulseBlk(0);
    chk("R7 single last", writeActive, 0); chk("R7 single count", blkCount, 6);
    chk("R8 no stop single", autoStopReq, 0);

    // R4 command-only accepted during read, data command refused
    issue(1, 1, 1, 1, 0, 3); pulseRsp();
    issue(0, 0, 0, 0, 0, 0);
    chk("R4 cmd accepted", cmdInhibit, 1); chk("R4 no conflict", cmdConflict, 0);
    chk("R4 read kept", readActive, 1); chk("R4 count kept", blkCount, 3);
    pulseRsp();
    chk("R4 read still", readActive, 1);
    issue(1, 0, 1, 1, 0, 7);
    chk("R4 data refused", cmdConflict, 1); chk("R4 inhibit stays 0", cmdInhibit, 0);
    chk("R4 count unchanged", blkCount, 3);
    pulseBlk(0);
    chk("R5 wrong event ignored", blkCount, 3);
    pulseBlk(1); pulseBlk(1); pulseBlk(1);
    chk("R5 read done", readActive, 0);

    // R9/R10 block gap on a write of 5
    issue(1, 0, 1, 1, 0, 5); pulseRsp();
    pulseBlk(0); pulseBlk(0);
    gapStop = 1;
    pulseBlk(0);
    chk("R9 parked", writeActive, 0); chk("R9 gap event", gapEvent, 1);
    chk("R9 count kept", blkCount, 2); chk("R11 gap complete", xferComplete, 1);
    @(negedge clk);
    chk("R9 one cycle", gapEvent, 0);
    issue(1, 1, 0, 0, 0, 1);
    chk("R4 refused while parked", cmdConflict, 1);
    gapContinue = 1; @(negedge clk); gapContinue = 0;
    chk("R10 blocked by stop", writeActive, 0);
    gapStop = 0;
    gapContinue = 1; @(negedge clk); gapContinue = 0;
    chk("R10 resumed", writeActive, 1); chk("R10 dat", datInhibit, 1);
    chk("R10 count", blkCount, 2);
    pulseBlk(0);
    chk("R10 count step", blkCount, 1); chk("R10 active", writeActive, 1);
    pulseBlk(0);
    chk("R10 finished", writeActive, 0); chk("R10 no gap", gapEvent, 0);

    // R7 uncounted multi-block never ends by itself, R9 gap on read
    issue(1, 1, 1, 0, 1, 4); pulseRsp();
    for (int i = 0; i < 20; i++) pulseBlk(1);
    chk("R7 uncounted active", readActive, 1); chk("R7 uncounted count", blkCount, 4);
    gapStop = 1; pulseBlk(1);
    chk("R9 read parked", readActive, 0); chk("R9 read gap", gapEvent, 1);
    chk("R8 no stop on gap", autoStopReq, 0);
    gapStop = 0;
    gapContinue = 1; @(negedge clk); gapContinue = 0;
    chk("R10 read resumed", readActive, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule